// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Decoder

This combinational block decodes a single instruction of variable length. Its input is a six-byte slice of instruction memory that starts at the current program counter. The first byte holds the opcode and function code. The opcode determines whether a register-specifier byte follows and whether a four-byte constant is present. These two facts fix the instruction length in bytes. The length in turn sets where the constant is taken from and how far the sequential next address is advanced.

Downstream decode and execute logic uses the results directly: the opcode and function nibbles, the two register IDs, the constant, a validity flag and the address of the next sequential instruction. The block does not contain the instruction memory, and it does not choose between branch targets and the sequential address.

Top module: `fetch_decode_top`

## Requirements
- R1: `icode_o` equals bits [7:4] of window byte 0, and `ifun_o` equals bits [3:0]. Window byte k sits at `win_i[8k+7:8k]`.
- R2: `instr_valid_o` is 1 exactly when the opcode lies in 0x0..0xB. Opcodes 0xC..0xF give 0.
- R3: The opcodes 2, 3, 4, 5, 6, 0xA and 0xB carry a register byte at window byte 1. For these, `ra_o` is its upper nibble and `rb_o` its lower nibble.
- R4: For any opcode without a register byte, both `ra_o` and `rb_o` read 8, the "no register" ID.
- R5: The opcodes 3, 4, 5, 7 and 8 carry a constant. `valc_o` is built little-endian from bytes 2..5 when a register byte is present, and from bytes 1..4 otherwise.
- R6: `valc_o` is 0 for any opcode without a constant.
- R7: `valp_o` = `pc_i` + length. The length is 1 for opcodes 0, 1 and 9; 2 for 2, 6, 0xA and 0xB; 5 for 7 and 8; and 6 for 3, 4 and 5.
- R8: For an invalid opcode, `valp_o` = `pc_i` + 1, `ra_o` = `rb_o` = 8 and `valc_o` = 0, whatever the other bytes hold.
- R9: The addition for `valp_o` wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 32 | Address of window byte 0 |
| win_i | input | 48 | Six fetched bytes, byte 0 in the low bits |
| icode_o | output | 4 | Opcode nibble |
| ifun_o | output | 4 | Function nibble |
| ra_o | output | 4 | First register ID, or 8 |
| rb_o | output | 4 | Second register ID, or 8 |
| valc_o | output | 32 | Constant word, or 0 |
| valp_o | output | 32 | Next sequential address |
| instr_valid_o | output | 1 | Opcode is defined |

## Verification
The immediate assertions assume that `pc_i` and `win_i` always hold known values. The bench therefore drives every input bit from time zero and never leaves a byte undefined. The assertions also take the window to be fully populated even for short instructions. For this reason the stimulus fills the unused trailing bytes with nonzero garbage, which exposes any field that is taken from the wrong offset. All sixteen opcodes are swept over several byte patterns and program counters, including one program counter that sits just below the top of the address space.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
  localparam int ADDR_W     = 32;
  localparam int WORD_BYTES = 4;
  localparam int WIN_BYTES  = WORD_BYTES + 2;
  localparam int WIN_W      = 8 * WIN_BYTES;
  localparam int WORD_W     = 8 * WORD_BYTES;
  localparam logic [3:0] REG_NONE = 4'h8;

  typedef enum logic [3:0] {
    OP_NOP   = 4'h0,
    OP_HALT  = 4'h1,
    OP_MOVRR = 4'h2,
    OP_MOVIR = 4'h3,
    OP_MOVRM = 4'h4,
    OP_MOVMR = 4'h5,
    OP_ALU   = 4'h6,
    OP_JMP   = 4'h7,
    OP_CALL  = 4'h8,
    OP_RET   = 4'h9,
    OP_PUSH  = 4'hA,
    OP_POP   = 4'hB
  } opcode_e;

  typedef struct packed {
    logic valid;
    logic need_reg;
    logic need_const;
  } op_class_t;
endpackage

// File: rtl/fd_op_class.sv
module fd_op_class
  import fetch_pkg::*;
(
  input  logic [3:0] icode_i,
  output op_class_t  cls_o
);
  always_comb begin
    cls_o = '0;
    case (icode_i)
      OP_NOP, OP_HALT, OP_RET: cls_o = '{valid: 1'b1, need_reg: 1'b0, need_const: 1'b0};
      OP_MOVRR, OP_ALU,
      OP_PUSH, OP_POP:         cls_o = '{valid: 1'b1, need_reg: 1'b1, need_const: 1'b0};
      OP_MOVIR, OP_MOVRM,
      OP_MOVMR:                cls_o = '{valid: 1'b1, need_reg: 1'b1, need_const: 1'b1};
      OP_JMP, OP_CALL:         cls_o = '{valid: 1'b1, need_reg: 1'b0, need_const: 1'b1};
      default:                 cls_o = '0;
    endcase
  end

  always_comb begin
    AST_INVALID_NO_FIELDS: assert (cls_o.valid || (!cls_o.need_reg && !cls_o.need_const)); // R8
  end
endmodule

// File: rtl/fd_align.sv
module fd_align
  import fetch_pkg::*;
#(
  parameter int NB = WORD_BYTES
) (
  input  logic [8*(NB+2)-1:0] win_i,
  input  logic                need_reg_i,
  input  logic                need_const_i,
  output logic [3:0]          ra_o,
  output logic [3:0]          rb_o,
  output logic [8*NB-1:0]     valc_o
);
  logic [NB-1:0][7:0] near_w;  // constant right after opcode byte
  logic [NB-1:0][7:0] far_w;   // constant after register byte

  for (genvar k = 0; k < NB; k++) begin : g_byte
    assign near_w[k] = win_i[8*(k+1) +: 8];
    assign far_w[k]  = win_i[8*(k+2) +: 8];
  end

  always_comb begin
    ra_o = need_reg_i ? win_i[15:12] : REG_NONE;
    rb_o = need_reg_i ? win_i[11:8]  : REG_NONE;
    if (!need_const_i)   valc_o = '0;
    else if (need_reg_i) valc_o = far_w;
    else                 valc_o = near_w;
  end

  always_comb begin
    AST_NOREG_NONE: assert (need_reg_i || (ra_o == REG_NONE && rb_o == REG_NONE)); // R4
    AST_NOCONST_ZERO: assert (need_const_i || valc_o == '0); // R6
  end
endmodule

// File: rtl/fd_pc_inc.sv
module fd_pc_inc
  import fetch_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int NB = WORD_BYTES
) (
  input  logic [AW-1:0] pc_i,
  input  logic          need_reg_i,
  input  logic          need_const_i,
  output logic [AW-1:0] valp_o
);
  localparam int LEN_W = $clog2(NB + 3);

  logic [LEN_W-1:0] len_w;

  always_comb begin
    len_w  = LEN_W'(1) + LEN_W'(need_reg_i) + (need_const_i ? LEN_W'(NB) : LEN_W'(0));
    valp_o = pc_i + AW'(len_w);
  end
endmodule

// File: rtl/fetch_decode_top.sv
module fetch_decode_top
  import fetch_pkg::*;
(
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [WIN_W-1:0]  win_i,
  output logic [3:0]        icode_o,
  output logic [3:0]        ifun_o,
  output logic [3:0]        ra_o,
  output logic [3:0]        rb_o,
  output logic [WORD_W-1:0] valc_o,
  output logic [ADDR_W-1:0] valp_o,
  output logic              instr_valid_o
);
  op_class_t cls_w;
  logic [ADDR_W-1:0] step_w;

  assign icode_o       = win_i[7:4];
  assign ifun_o        = win_i[3:0];
  assign instr_valid_o = cls_w.valid;

  fd_op_class u_class (
    .icode_i (win_i[7:4]),
    .cls_o   (cls_w)
  );

  fd_align #(.NB(WORD_BYTES)) u_align (
    .win_i        (win_i),
    .need_reg_i   (cls_w.need_reg),
    .need_const_i (cls_w.need_const),
    .ra_o         (ra_o),
    .rb_o         (rb_o),
    .valc_o       (valc_o)
  );

  fd_pc_inc #(.AW(ADDR_W), .NB(WORD_BYTES)) u_pc_inc (
    .pc_i         (pc_i),
    .need_reg_i   (cls_w.need_reg),
    .need_const_i (cls_w.need_const),
    .valp_o       (valp_o)
  );

  assign step_w = valp_o - pc_i;

  always_comb begin
    AST_LEN_LEGAL: assert (step_w == 1 || step_w == 2 || step_w == WORD_BYTES + 1 ||
                           step_w == WORD_BYTES + 2); // R7
    AST_INVALID_SHORT: assert (instr_valid_o || step_w == 1); // R8
  end
endmodule

// File: tb/sim_fetch_decode_top.sv
module sim_fetch_decode_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] pc;
  logic [47:0] win;
  logic [3:0]  icode, ifun, ra, rb;
  logic [31:0] valc, valp;
  logic        valid;
  int n_run = 0, n_fail = 0;

  fetch_decode_top u0 (
    .pc_i(pc), .win_i(win), .icode_o(icode), .ifun_o(ifun), .ra_o(ra), .rb_o(rb),
    .valc_o(valc), .valp_o(valp), .instr_valid_o(valid)
  );

  initial begin pc = '0; win = '0; end

  function automatic logic [47:0] mk(input logic [7:0] b0, b1, b2, b3, b4, b5);
    return {b5, b4, b3, b2, b1, b0};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h (pc=%h win=%h)", req, act, exp, pc, win);
    end
  endtask

  task automatic drive(input logic [31:0] p, input logic [47:0] w);
    @(negedge clk);
    pc = p; win = w;
    #5;
  endtask

  // independent reference from the requirement tables
  task automatic check_model(input logic [31:0] p, input logic [47:0] w);
    logic [3:0] op;
    logic v, r, c;
    logic [31:0] ec;
    int len;
    op = w[7:4];
    v = (op <= 4'hB);
    r = (op inside {4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'hA, 4'hB});
    c = (op inside {4'h3, 4'h4, 4'h5, 4'h7, 4'h8});
    len = 1 + (r ? 1 : 0) + (c ? 4 : 0);
    ec = !c ? 32'h0 : (r ? w[47:16] : w[39:8]);
    drive(p, w);
    chk("R1", {24'h0, icode, ifun}, {24'h0, w[7:0]});
    chk("R2", {31'h0, valid}, {31'h0, v});
    chk("R3_R4", {24'h0, ra, rb}, r ? {24'h0, w[15:8]} : 32'h88);
    chk("R5_R6", valc, ec);
    chk("R7", valp, p + len);
  endtask

  task automatic t_idle();
    drive(32'h0, '0);
    chk("R1", {28'h0, icode}, 32'h0);
    chk("R2", {31'h0, valid}, 32'h1);
    chk("R7", valp, 32'h1);
  endtask

  task automatic t_reg_only();
    drive(32'h100, mk(8'h61, 8'h3C, 8'hAA, 8'hBB, 8'hCC, 8'hDD));
    chk("R3", {28'h0, ra}, 32'h3);
    chk("R3", {28'h0, rb}, 32'hC);
    chk("R6", valc, 32'h0);
    chk("R7", valp, 32'h102);
  endtask

  task automatic t_imm_move();
    drive(32'h200, mk(8'h30, 8'h82, 8'h78, 8'h56, 8'h34, 8'h12));
    chk("R5", valc, 32'h12345678);
    chk("R3", {24'h0, ra, rb}, 32'h82);
    chk("R7", valp, 32'h206);
  endtask

  task automatic t_jump();
    drive(32'h300, mk(8'h74, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55));
    chk("R5", valc, 32'h44332211);
    chk("R4", {24'h0, ra, rb}, 32'h88);
    chk("R1", {28'h0, ifun}, 32'h4);
    chk("R7", valp, 32'h305);
  endtask

  task automatic t_invalid();
    drive(32'h400, mk(8'hC5, 8'h12, 8'h34, 8'h56, 8'h78, 8'h9A));
    chk("R2", {31'h0, valid}, 32'h0);
    chk("R8", valp, 32'h401);
    chk("R8", {24'h0, ra, rb}, 32'h88);
    chk("R8", valc, 32'h0);
  endtask

  task automatic t_wrap();
    drive(32'hFFFF_FFFE, mk(8'h50, 8'h12, 8'h01, 8'h02, 8'h03, 8'h04));
    chk("R9", valp, 32'h4);
    drive(32'hFFFF_FFFF, mk(8'h00, 8'h12, 8'h01, 8'h02, 8'h03, 8'h04));
    chk("R9", valp, 32'h0);
  endtask

  task automatic t_sweep();
    for (int op = 0; op < 16; op++) begin
      for (int pat = 0; pat < 3; pat++) begin
        logic [47:0] w;
        logic [31:0] p;
        w = {40'hF1E2D3C4B5 ^ {5{8'(pat * 37)}}, 4'(op), 4'(pat + op)};
        p = 32'h1000_0000 * pat + 32'(op * 13);
        check_model(p, w);
      end
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    finish_run();
  end

  initial begin
    repeat (2) @(posedge clk);
    t_idle();
    t_reg_only();
    t_imm_move();
    t_jump();
    t_invalid();
    t_wrap();
    t_sweep();
    finish_run();
  end
endmodule